// File: doc/BRIEF.md
# Receive Fill-Character Discard Filter

This block sits between a character decoder and a receive buffer. Each incoming character is an 8-bit code plus a flag that marks it as a special (control) character, and a side flag marks the character that carries the serial address. A 2-bit policy input picks how much of the stream is thinned out. The filter can drop idle fill characters, either all of them or every fill but the last one of a run. It can also drop address characters and the two command characters. The two command characters set and clear an interrupt line, which copies a level signalled from the far end of the link.

In bypass mode nothing is removed. Every character still reaches the output, and a per-character empty flag marks the ones the active policy would have dropped, so that a downstream consumer can do the filtering. Keeping only the last fill of a run needs one character of lookahead. A single slot register holds either a pending fill or a character that is queued behind an emitted fill. The output is a registered character with a valid strobe.

Policy and bypass are expected to change only while the input is idle and nothing is held.

Top module: `fdf_filter`

## Requirements
- R1: After synchronous reset, out_valid and irq_out are 0 and any held or pending character is discarded.
- R2: Policy 0 passes every input character to the output one cycle after it is accepted, with out_empty 0, including fills and command characters.
- R3: Under policy 1, a run of consecutive fill characters (special, code 0x05) produces exactly one output, the last fill of the run. It is emitted in the cycle the first non-fill character arrives. That character is then held and emitted one cycle later.
- R4: Under policy 2, every fill character is removed and other data passes.
- R5: Under policy 3, fills and characters marked by in_addr are removed. Under policy 2, address-marked characters pass.
- R6: The command characters (special code 0x00 = set, special code 0x03 = clear) are removed under policies 1, 2 and 3 and passed under policy 0. A command that ends a policy-1 fill run still releases the pending fill.
- R7: irq_out becomes 1 in the cycle after a set command is accepted and 0 in the cycle after a clear command is accepted, under any policy or bypass setting. It is otherwise unchanged.
- R8: In bypass mode, every character is output. out_empty is 1 exactly for characters the policy would drop, so under policy 0 it is never 1.
- R9: In bypass mode with policy 1, every fill of a run except the last is output with out_empty 1 (each when the next fill arrives), and the last one with out_empty 0 when a non-fill arrives.
- R10: With no fill pending, a kept character appears one cycle after acceptance. A held character is emitted in the first idle input cycle, and no output is produced while the input is idle and nothing is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Discard policy 0..3 |
| bypass | input | 1 | 1: keep all characters, flag discards with out_empty |
| in_valid | input | 1 | Input character present this cycle |
| in_special | input | 1 | Input character is a special character |
| in_char | input | 8 | Input character code |
| in_addr | input | 1 | Input character is the serial address |
| out_valid | output | 1 | Output character valid |
| out_special | output | 1 | Output character is special |
| out_char | output | 8 | Output character code |
| out_empty | output | 1 | Output character would have been discarded (bypass only) |
| irq_out | output | 1 | Interrupt level set/cleared by command characters |

## Verification
The filter is driven with fill runs of length one, two and five ended by data, by a command and by idle gaps. This separates keeping the last fill from keeping the first fill or every fill, and shows that the character queued behind a released fill comes out one cycle later. Address-marked characters are sent under policies 2 and 3 to show that only the top policy removes them. Every policy is also repeated in bypass mode, where the same stimulus must produce the same characters with an empty flag in place of each drop. Set and clear commands are interleaved under policy 0 and policy 1 to show that the interrupt follows them whether or not the command itself is removed.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

    parameter int CHW = 8;

    localparam logic [CHW-1:0] FILL_CODE = CHW'(8'h05);
    localparam logic [CHW-1:0] SET_CODE  = CHW'(8'h00);
    localparam logic [CHW-1:0] CLR_CODE  = CHW'(8'h03);

    typedef enum logic [1:0] {
        POL_KEEP_ALL     = 2'd0,
        POL_LAST_FILL    = 2'd1,
        POL_NO_FILL      = 2'd2,
        POL_NO_FILL_ADDR = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_FILL  = 2'd1,
        SL_HELD  = 2'd2
    } slot_e;

    typedef struct packed {
        logic           sp;
        logic [CHW-1:0] code;
    } sym_t;

    typedef struct packed {
        logic is_fill;
        logic is_set;
        logic is_clr;
        logic drop;
    } class_t;

    function automatic class_t classify(input policy_e pol, input sym_t s, input logic addr);
        class_t c;
        c.is_fill = s.sp && (s.code == FILL_CODE);
        c.is_set  = s.sp && (s.code == SET_CODE);
        c.is_clr  = s.sp && (s.code == CLR_CODE);
        unique case (pol)
            POL_KEEP_ALL:     c.drop = 1'b0;
            POL_LAST_FILL:    c.drop = c.is_set || c.is_clr;
            POL_NO_FILL:      c.drop = c.is_set || c.is_clr || c.is_fill;
            default:          c.drop = c.is_set || c.is_clr || c.is_fill || addr;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fdf_classify.sv
module fdf_classify
    import fdf_pkg::*;
(
    input  policy_e policy,
    input  sym_t    sym,
    input  logic    addr,
    output class_t  cls
);
    always_comb cls = classify(policy, sym, addr);
endmodule

// File: rtl/fdf_irq.sv
module fdf_irq
    import fdf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  class_t cls,
    output logic   irq
);
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (in_valid && cls.is_set)
            irq <= 1'b1;
        else if (in_valid && cls.is_clr)
            irq <= 1'b0;
    end

    // R7: set command raises the line one cycle later
    a_r7_set: assert property (@(posedge clk) disable iff (rst)
        in_valid && cls.is_set |=> irq);
    // R7: clear command lowers the line one cycle later
    a_r7_clr: assert property (@(posedge clk) disable iff (rst)
        in_valid && cls.is_clr |=> !irq);
    // R7: no command, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && (cls.is_set || cls.is_clr)) |=> $stable(irq));
endmodule

// File: rtl/fdf_lookahead.sv
module fdf_lookahead
    import fdf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  policy_e policy,
    input  logic    bypass,
    input  logic    in_valid,
    input  sym_t    sym,
    input  class_t  cls,
    output logic    out_valid,
    output sym_t    out_sym,
    output logic    out_empty
);
    slot_e slot_q, slot_d;
    sym_t  slot_sym_q, slot_sym_d;
    logic  slot_emp_q, slot_emp_d;

    logic  emit;
    sym_t  emit_sym;
    logic  emit_emp;

    logic  kept, look;

    always_comb begin
        kept = !cls.drop || bypass;
        look = (policy == POL_LAST_FILL) && cls.is_fill;

        slot_d     = slot_q;
        slot_sym_d = slot_sym_q;
        slot_emp_d = slot_emp_q;
        emit       = 1'b0;
        emit_sym   = slot_sym_q;
        emit_emp   = slot_emp_q;

        if (in_valid) begin
            if (look) begin
                if (slot_q == SL_FILL) begin
                    // overwritten fill: dropped, or flagged in bypass
                    emit     = bypass;
                    emit_emp = 1'b1;
                end else if (slot_q == SL_HELD) begin
                    emit = 1'b1;
                end
                slot_d     = SL_FILL;
                slot_sym_d = sym;
                slot_emp_d = 1'b0;
            end else if (kept) begin
                if (slot_q != SL_EMPTY) begin
                    emit       = 1'b1;
                    slot_d     = SL_HELD;
                    slot_sym_d = sym;
                    slot_emp_d = cls.drop;
                end else begin
                    emit     = 1'b1;
                    emit_sym = sym;
                    emit_emp = cls.drop;
                end
            end else if (slot_q != SL_EMPTY) begin
                emit   = 1'b1;
                slot_d = SL_EMPTY;
            end
        end else if (slot_q == SL_HELD ||
                     (slot_q == SL_FILL && policy != POL_LAST_FILL)) begin
            emit   = 1'b1;
            slot_d = SL_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= SL_EMPTY;
            slot_sym_q <= '0;
            slot_emp_q <= 1'b0;
            out_valid  <= 1'b0;
            out_sym    <= '0;
            out_empty  <= 1'b0;
        end else begin
            slot_q     <= slot_d;
            slot_sym_q <= slot_sym_d;
            slot_emp_q <= slot_emp_d;
            out_valid  <= emit;
            if (emit) begin
                out_sym   <= emit_sym;
                out_empty <= emit_emp && bypass;
            end
        end
    end

    // R8: empty flag only ever reported in bypass mode
    a_r8_empty_only_bypass: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_empty |-> $past(bypass));
    // R10: idle input with nothing held gives no output
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid && slot_q == SL_EMPTY |=> !out_valid);
    // R3: a fill following a pending fill produces nothing outside bypass
    a_r3_fill_overwrite: assert property (@(posedge clk) disable iff (rst)
        in_valid && look && !bypass && slot_q == SL_FILL |=> !out_valid);
endmodule

// File: rtl/fdf_filter.sv
module fdf_filter
    import fdf_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     policy,
    input  logic           bypass,
    input  logic           in_valid,
    input  logic           in_special,
    input  logic [CHW-1:0] in_char,
    input  logic           in_addr,
    output logic           out_valid,
    output logic           out_special,
    output logic [CHW-1:0] out_char,
    output logic           out_empty,
    output logic           irq_out
);
    policy_e pol;
    sym_t    in_sym, o_sym;
    class_t  cls;

    assign pol    = policy_e'(policy);
    assign in_sym = '{sp: in_special, code: in_char};

    fdf_classify u_class (
        .policy (pol),
        .sym    (in_sym),
        .addr   (in_addr),
        .cls    (cls)
    );

    fdf_lookahead u_look (
        .clk       (clk),
        .rst       (rst),
        .policy    (pol),
        .bypass    (bypass),
        .in_valid  (in_valid),
        .sym       (in_sym),
        .cls       (cls),
        .out_valid (out_valid),
        .out_sym   (o_sym),
        .out_empty (out_empty)
    );

    fdf_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .cls      (cls),
        .irq      (irq_out)
    );

    assign out_special = o_sym.sp;
    assign out_char    = o_sym.code;

    // R1: reset leaves the outputs quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !irq_out);
endmodule

// File: tb/fdf_filter_tb.sv
`timescale 1ns/1ps
module fdf_filter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] policy = 2'd0;
    logic       bypass = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_special = 1'b0;
    logic [7:0] in_char = 8'h00;
    logic       in_addr = 1'b0;
    logic       out_valid, out_special, out_empty, irq_out;
    logic [7:0] out_char;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    fdf_filter u_dut (
        .clk(clk), .rst(rst), .policy(policy), .bypass(bypass),
        .in_valid(in_valid), .in_special(in_special), .in_char(in_char),
        .in_addr(in_addr), .out_valid(out_valid), .out_special(out_special),
        .out_char(out_char), .out_empty(out_empty), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [1:0] pol;
        logic       byp;
        logic       v;
        logic       sp;
        logic       ad;
        logic [7:0] ch;
        logic       ev;
        logic       esp;
        logic [7:0] ech;
        logic       eemp;
        logic       eirq;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 30;
    // inputs: pol byp v sp ad ch | expected after the edge: ev esp ech eemp eirq | req
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b0,1'b1,1'b0,1'b0,8'h11, 1'b1,1'b0,8'h11,1'b0,1'b0, 4'd2},  // R2
        '{2'd0,1'b0,1'b1,1'b1,1'b0,8'h05, 1'b1,1'b1,8'h05,1'b0,1'b0, 4'd2},  // R2 fill kept
        '{2'd0,1'b0,1'b1,1'b1,1'b0,8'h00, 1'b1,1'b1,8'h00,1'b0,1'b1, 4'd6},  // R6 set passed
        '{2'd0,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00,1'b0,1'b1, 4'd7},  // R7 holds
        '{2'd1,1'b0,1'b1,1'b1,1'b0,8'h05, 1'b0,1'b0,8'h00,1'b0,1'b1, 4'd3},  // R3 pending
        '{2'd1,1'b0,1'b1,1'b1,1'b0,8'h05, 1'b0,1'b0,8'h00,1'b0,1'b1, 4'd3},  // R3 overwrite
        '{2'd1,1'b0,1'b1,1'b0,1'b0,8'h22, 1'b1,1'b1,8'h05,1'b0,1'b1, 4'd3},  // R3 fill out
        '{2'd1,1'b0,1'b1,1'b0,1'b0,8'h33, 1'b1,1'b0,8'h22,1'b0,1'b1, 4'd3},  // R3 held out
        '{2'd1,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h33,1'b0,1'b1, 4'd10}, // R10 drain
        '{2'd1,1'b0,1'b1,1'b0,1'b0,8'h44, 1'b1,1'b0,8'h44,1'b0,1'b1, 4'd10}, // R10 direct
        '{2'd1,1'b0,1'b1,1'b1,1'b0,8'h05, 1'b0,1'b0,8'h00,1'b0,1'b1, 4'd3},
        '{2'd1,1'b0,1'b1,1'b1,1'b0,8'h03, 1'b1,1'b1,8'h05,1'b0,1'b0, 4'd6},  // R6 clr ends run
        '{2'd1,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0, 4'd6},  // R6 clr dropped
        '{2'd2,1'b0,1'b1,1'b1,1'b0,8'h05, 1'b0,1'b0,8'h00,1'b0,1'b0, 4'd4},  // R4
        '{2'd2,1'b0,1'b1,1'b0,1'b0,8'h55, 1'b1,1'b0,8'h55,1'b0,1'b0, 4'd4},  // R4
        '{2'd2,1'b0,1'b1,1'b0,1'b1,8'h66, 1'b1,1'b0,8'h66,1'b0,1'b0, 4'd5},  // R5 addr kept p2
        '{2'd3,1'b0,1'b1,1'b0,1'b1,8'h77, 1'b0,1'b0,8'h00,1'b0,1'b0, 4'd5},  // R5 addr dropped
        '{2'd3,1'b0,1'b1,1'b0,1'b0,8'h88, 1'b1,1'b0,8'h88,1'b0,1'b0, 4'd5},
        '{2'd3,1'b0,1'b1,1'b1,1'b0,8'h05, 1'b0,1'b0,8'h00,1'b0,1'b0, 4'd5},
        '{2'd3,1'b1,1'b1,1'b1,1'b0,8'h05, 1'b1,1'b1,8'h05,1'b1,1'b0, 4'd8},  // R8 fill flagged
        '{2'd3,1'b1,1'b1,1'b0,1'b1,8'h99, 1'b1,1'b0,8'h99,1'b1,1'b0, 4'd8},  // R8 addr flagged
        '{2'd3,1'b1,1'b1,1'b0,1'b0,8'h12, 1'b1,1'b0,8'h12,1'b0,1'b0, 4'd8},
        '{2'd3,1'b1,1'b1,1'b1,1'b0,8'h00, 1'b1,1'b1,8'h00,1'b1,1'b1, 4'd7},  // R7 in bypass
        '{2'd1,1'b1,1'b1,1'b1,1'b0,8'h05, 1'b0,1'b0,8'h00,1'b0,1'b1, 4'd9},  // R9
        '{2'd1,1'b1,1'b1,1'b1,1'b0,8'h05, 1'b1,1'b1,8'h05,1'b1,1'b1, 4'd9},  // R9 earlier fill
        '{2'd1,1'b1,1'b1,1'b0,1'b0,8'h34, 1'b1,1'b1,8'h05,1'b0,1'b1, 4'd9},  // R9 last fill
        '{2'd1,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,8'h34,1'b0,1'b1, 4'd9},
        '{2'd0,1'b1,1'b1,1'b1,1'b0,8'h05, 1'b1,1'b1,8'h05,1'b0,1'b1, 4'd8},  // R8 p0 never empty
        '{2'd0,1'b1,1'b1,1'b1,1'b0,8'h03, 1'b1,1'b1,8'h03,1'b0,1'b0, 4'd8},
        '{2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00,1'b0,1'b0, 4'd10}
    };

    task automatic check(input bit ok, input int req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: got {v,e,irq,sp,ch}=%h expected %h", req, act, exp);
        end
    endtask

    // drive one input at the falling edge, sample outputs at the next falling edge
    task automatic step(input logic [1:0] p, input logic b, input logic v,
                        input logic sp, input logic ad, input logic [7:0] ch);
        policy = p; bypass = b; in_valid = v; in_special = sp; in_addr = ad; in_char = ch;
        @(negedge clk);
    endtask

    function automatic logic [11:0] act_word();
        return {out_valid, out_empty, irq_out, out_special, out_char};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int nfill;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!out_valid && !irq_out, 1, act_word(), 12'h000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t t;
            logic [11:0] exp;
            bit ok;
            t = VECS[i];
            step(t.pol, t.byp, t.v, t.sp, t.ad, t.ch);
            exp = {t.ev, t.eemp, t.eirq, t.esp, t.ech};
            if (t.ev)
                ok = (act_word() == exp);
            else
                ok = !out_valid && (irq_out == t.eirq);
            check(ok, int'(t.rq), act_word(), exp);
        end

        // R3: run of five fills gives one output, released by data
        nfill = 0;
        for (int k = 0; k < 5; k++) begin
            step(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05);
            if (out_valid) nfill++;
        end
        check(nfill == 0, 3, 12'(nfill), 12'd0);
        step(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A);
        check(out_valid && out_special && out_char == 8'h05, 3, act_word(), 12'h905);
        step(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check(out_valid && !out_special && out_char == 8'h5A, 3, act_word(), 12'h85A);
        step(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check(!out_valid, 10, act_word(), 12'h000);

        // R1: reset clears a pending fill and the interrupt
        step(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
        check(irq_out == 1'b1, 7, act_word(), 12'h200);
        step(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05);
        rst = 1'b1;
        step(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        rst = 1'b0;
        check(!out_valid && !irq_out, 1, act_word(), 12'h000);
        step(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h21);
        check(out_valid && out_char == 8'h21 && !out_special, 1, act_word(), 12'h821);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule